// File: doc/BRIEF.md
# Programmable Chip-Select Bus Timing Sequencer

This block carries out one access at a time on an asynchronous parallel bus for a single chip-select region. A requester hands over a read or write with an address and write data through a valid/ready handshake. The sequencer then drives the active-low chip enable, read strobe and write strobe through a fixed series of phases. The phase lengths come from static timing inputs that software sets.

Each phase length is a small count, plus one, times a clock multiplier chosen by a 2-bit code. With wait mode on, a device ready line can hold the strobe beyond its programmed width. A guard counter ends an access whose ready line never comes back and reports an error. For reads, the value on the data bus is captured on the last clock of the strobe. It is returned together with a one-cycle response pulse once the access has fully closed.

Top module: `cs_bus_timer`

## Requirements
- R1: After reset and while idle, bus_ce_n, bus_oe_n and bus_we_n are all high, rsp_valid is low, and req_ready is high when the region is enabled.
- R2: A phase programmed with count c lasts (c+1)*M clock cycles, where M depends on cfg_mult: code 0 gives M=4, code 1 gives M=1, code 2 gives M=2 and code 3 gives M=8.
- R3: An access runs its phases in a fixed order. First comes address setup with bus_ce_n high (cfg_adr). Then bus_ce_n goes low with the strobe still high (cfg_ce). Then the strobe is low. Then a hold follows with bus_ce_n low and the strobe high. Last comes a pause with bus_ce_n high again (cfg_pause).
- R4: A read drives bus_oe_n low for the cfg_oe width and then holds for cfg_rd_hld. A write drives bus_we_n low for the cfg_we width and then holds for cfg_wr_hld. The other strobe stays high. A write leaves rsp_rdata unchanged.
- R5: With cfg_wait_en=1, the strobe stays low after its programmed width for as long as bus_rdy is low. Once bus_rdy is high, the strobe stays low for a further (cfg_wait+1)*M cycles. With cfg_wait_en=0, bus_rdy has no effect.
- R6: For a read, rsp_rdata is the value on bus_rdata in the last clock cycle in which the strobe is low. It is presented with rsp_valid.
- R7: While cfg_en is low, req_ready stays low, requests are ignored, and bus_ce_n stays high.
- R8: req_ready is low from the cycle after acceptance until the pause ends. rsp_valid is high for exactly one cycle, the first idle cycle after the pause.
- R9: In wait mode, if bus_rdy stays low for TMO_CYCLES cycles after the programmed strobe width, the strobe ends and the access completes through hold and pause. rsp_err is then high with rsp_valid. rsp_err is low for the response of a normal access.
- R10: bus_addr and bus_wdata hold the accepted request's values for the whole access, and bus_wdata_oe is high during every non-idle cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult | input | 2 | Multiplier code (0:x4, 1:x1, 2:x2, 3:x8) |
| cfg_wait_en | input | 1 | Wait-mode enable |
| cfg_adr | input | CW | Address setup count |
| cfg_ce | input | CW | Chip-enable to strobe count |
| cfg_oe | input | CW | Read strobe width count |
| cfg_we | input | CW | Write strobe width count |
| cfg_rd_hld | input | CW | Read hold count |
| cfg_wr_hld | input | CW | Write hold count |
| cfg_pause | input | CW | Closing pause count |
| cfg_wait | input | CW | Strobe extension after ready count |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| rsp_err | output | 1 | Wait timeout flag, valid with rsp_valid |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DW | Bus read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_rdy | input | 1 | Device ready |

## Verification
A wrong phase state or a miscounted phase timer appears at the bus pins within that same access. The edges of bus_ce_n or a strobe move by one or more cycles, and the phase lengths the bench measures no longer equal (c+1)*M. A sampling error shows up in rsp_rdata at the closing response, because the bench changes bus_rdata on every strobe cycle. A stuck wait state appears as a strobe that runs too long, or as a wrong rsp_err at the end of the access.

// File: rtl/cs_bus_pkg.sv
// Shared types for the chip-select timing sequencer.
// Assumes: the multiplier code mapping is fixed and known to software.
package cs_bus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADR,
        PH_CE,
        PH_STB,
        PH_WRDY,
        PH_WEXT,
        PH_HLD,
        PH_PAUSE
    } phase_t;

    // Shift amount for a multiplier code: 0->x4, 1->x1, 2->x2, 3->x8.
    function automatic logic [1:0] mult_shift(input logic [1:0] code);
        case (code)
            2'd0:    mult_shift = 2'd2;
            2'd1:    mult_shift = 2'd0;
            2'd2:    mult_shift = 2'd1;
            default: mult_shift = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/cs_len_scale.sv
// Converts one programmed phase count into a length in clock cycles.
// Assumes: LW >= CW + 4, so that (2^CW) * 8 fits.
module cs_len_scale
    import cs_bus_pkg::*;
#(
    parameter int CW = 6,
    parameter int LW = CW + 4
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [1:0]    mult_i,
    output logic [LW-1:0] len_o
);

    logic [LW-1:0] base;

    // Length = (count + 1) scaled by the selected power-of-two multiplier.
    always_comb begin
        base  = LW'(cnt_i) + LW'(1);
        len_o = base << mult_shift(mult_i);
    end

endmodule

// File: rtl/cs_phase_timer.sv
// Down counter that times the current phase.
// Assumes: load is asserted on the last cycle of the previous phase; len_i >= 1.
module cs_phase_timer #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] len_i,
    output logic          zero_o
);

    logic [LW-1:0] cnt_q;

    // Load length minus one, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i - LW'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - LW'(1);
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cs_wait_guard.sv
// Counts cycles spent waiting for device ready and flags expiry.
// Assumes: TMO_CYCLES >= 2; active_i is high only in the wait state.
module cs_wait_guard #(
    parameter int TMO_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic expire_o
);

    localparam int GW = $clog2(TMO_CYCLES);

    logic [GW-1:0] cnt_q;

    // Count while waiting, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i)
            cnt_q <= '0;
        else if (cnt_q != GW'(TMO_CYCLES - 1))
            cnt_q <= cnt_q + GW'(1);
    end

    assign expire_o = active_i && (cnt_q == GW'(TMO_CYCLES - 1));

endmodule

// File: rtl/cs_bus_timer.sv
// Chip-select bus timing sequencer: runs one parallel-bus access per
// accepted request through address setup, enable delay, strobe, optional
// ready wait and extension, hold and pause.
// Assumes: the cfg_* inputs are static while an access is in progress.
module cs_bus_timer
    import cs_bus_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int CW         = 6,
    parameter int TMO_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mult,
    input  logic          cfg_wait_en,
    input  logic [CW-1:0] cfg_adr,
    input  logic [CW-1:0] cfg_ce,
    input  logic [CW-1:0] cfg_oe,
    input  logic [CW-1:0] cfg_we,
    input  logic [CW-1:0] cfg_rd_hld,
    input  logic [CW-1:0] cfg_wr_hld,
    input  logic [CW-1:0] cfg_pause,
    input  logic [CW-1:0] cfg_wait,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_ce_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    input  logic          bus_rdy
);

    localparam int LW    = CW + 4;
    localparam int NF    = 8;
    localparam int F_ADR = 0;
    localparam int F_CE  = 1;
    localparam int F_OE  = 2;
    localparam int F_WE  = 3;
    localparam int F_RH  = 4;
    localparam int F_WH  = 5;
    localparam int F_PS  = 6;
    localparam int F_WT  = 7;

    phase_t                 state_q, state_d;
    logic                   write_q;
    logic [AW-1:0]          addr_q;
    logic [DW-1:0]          wdata_q;
    logic [DW-1:0]          rdata_q;
    logic                   err_q;
    logic                   rsp_valid_q;
    logic [NF-1:0][CW-1:0]  fcnt;
    logic [NF-1:0][LW-1:0]  flen;
    logic                   accept;
    logic                   load;
    logic [LW-1:0]          load_len;
    logic                   sample;
    logic                   abort;
    logic                   done;
    logic                   tmr_zero;
    logic                   wait_expire;
    logic [LW-1:0]          stb_len;
    logic [LW-1:0]          hld_len;

    // Gather the programmed counts into one indexed array.
    always_comb begin
        fcnt[F_ADR] = cfg_adr;
        fcnt[F_CE]  = cfg_ce;
        fcnt[F_OE]  = cfg_oe;
        fcnt[F_WE]  = cfg_we;
        fcnt[F_RH]  = cfg_rd_hld;
        fcnt[F_WH]  = cfg_wr_hld;
        fcnt[F_PS]  = cfg_pause;
        fcnt[F_WT]  = cfg_wait;
    end

    for (genvar g = 0; g < NF; g++) begin : g_scale
        cs_len_scale #(.CW(CW), .LW(LW)) u_scale (
            .cnt_i  (fcnt[g]),
            .mult_i (cfg_mult),
            .len_o  (flen[g])
        );
    end

    cs_phase_timer #(.LW(LW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .len_i  (load_len),
        .zero_o (tmr_zero)
    );

    cs_wait_guard #(.TMO_CYCLES(TMO_CYCLES)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (state_q == PH_WRDY),
        .expire_o (wait_expire)
    );

    assign req_ready = (state_q == PH_IDLE) && cfg_en;
    assign accept    = req_valid && req_ready;
    assign stb_len   = write_q ? flen[F_WE] : flen[F_OE];
    assign hld_len   = write_q ? flen[F_WH] : flen[F_RH];

    // Next phase, timer load and sample/abort/done decisions.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_len = flen[F_ADR];
        sample   = 1'b0;
        abort    = 1'b0;
        done     = 1'b0;
        case (state_q)
            PH_IDLE: begin
                if (accept) begin
                    state_d  = PH_ADR;
                    load     = 1'b1;
                    load_len = flen[F_ADR];
                end
            end
            PH_ADR: begin
                if (tmr_zero) begin
                    state_d  = PH_CE;
                    load     = 1'b1;
                    load_len = flen[F_CE];
                end
            end
            PH_CE: begin
                if (tmr_zero) begin
                    state_d  = PH_STB;
                    load     = 1'b1;
                    load_len = stb_len;
                end
            end
            PH_STB: begin
                if (tmr_zero) begin
                    if (cfg_wait_en && !bus_rdy) begin
                        state_d = PH_WRDY;
                    end else if (cfg_wait_en) begin
                        state_d  = PH_WEXT;
                        load     = 1'b1;
                        load_len = flen[F_WT];
                    end else begin
                        state_d  = PH_HLD;
                        load     = 1'b1;
                        load_len = hld_len;
                        sample   = 1'b1;
                    end
                end
            end
            PH_WRDY: begin
                if (bus_rdy) begin
                    state_d  = PH_WEXT;
                    load     = 1'b1;
                    load_len = flen[F_WT];
                end else if (wait_expire) begin
                    state_d  = PH_HLD;
                    load     = 1'b1;
                    load_len = hld_len;
                    sample   = 1'b1;
                    abort    = 1'b1;
                end
            end
            PH_WEXT: begin
                if (tmr_zero) begin
                    state_d  = PH_HLD;
                    load     = 1'b1;
                    load_len = hld_len;
                    sample   = 1'b1;
                end
            end
            PH_HLD: begin
                if (tmr_zero) begin
                    state_d  = PH_PAUSE;
                    load     = 1'b1;
                    load_len = flen[F_PS];
                end
            end
            PH_PAUSE: begin
                if (tmr_zero) begin
                    state_d = PH_IDLE;
                    done    = 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture read data on the last strobe cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (sample && !write_q)
            rdata_q <= bus_rdata;
    end

    // Error flag: cleared per access, set on wait timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)
            err_q <= 1'b0;
        else if (abort)
            err_q <= 1'b1;
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_valid_q <= 1'b0;
        else
            rsp_valid_q <= done;
    end

    assign rsp_valid    = rsp_valid_q;
    assign rsp_rdata    = rdata_q;
    assign rsp_err      = rsp_valid_q && err_q;
    assign bus_addr     = addr_q;
    assign bus_wdata    = wdata_q;
    assign bus_wdata_oe = write_q && (state_q != PH_IDLE);

    // Strobe decode from the phase register.
    always_comb begin
        logic ce_on;
        logic stb_on;
        ce_on    = (state_q == PH_CE) || (state_q == PH_STB) || (state_q == PH_WRDY)
                || (state_q == PH_WEXT) || (state_q == PH_HLD);
        stb_on   = (state_q == PH_STB) || (state_q == PH_WRDY) || (state_q == PH_WEXT);
        bus_ce_n = !ce_on;
        bus_oe_n = !(stb_on && !write_q);
        bus_we_n = !(stb_on && write_q);
    end

endmodule

// File: rtl/cs_bus_timer_chk.sv
// Protocol checker for the chip-select timing sequencer, attached by bind.
// Assumes: observes only top-level ports.
module cs_bus_timer_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_en,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ce_n,
    input logic          bus_oe_n,
    input logic          bus_we_n
);

    // R3: a strobe is only low while chip enable is low.
    p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce_n |-> (bus_oe_n && bus_we_n));

    // R4: never both strobes at once.
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    // R8: no new request accepted during a bus access.
    p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce_n |-> !req_ready);

    // R8: completion is a single-cycle pulse.
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: disabled region never offers ready.
    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !req_ready);

    // R10: address and write data stable while chip enable is held.
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ce_n && $past(!bus_ce_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

endmodule

bind cs_bus_timer cs_bus_timer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ce_n  (bus_ce_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n)
);

// File: tb/cs_bus_timer_tb.sv
// Directed bench for the chip-select timing sequencer.
module cs_bus_timer_tb;

    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int CW  = 6;
    localparam int TMO = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_en;
    logic [1:0]    cfg_mult;
    logic          cfg_wait_en;
    logic [CW-1:0] cfg_adr, cfg_ce, cfg_oe, cfg_we;
    logic [CW-1:0] cfg_rd_hld, cfg_wr_hld, cfg_pause, cfg_wait;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wdata_oe;
    logic [DW-1:0] bus_rdata;
    logic          bus_ce_n, bus_oe_n, bus_we_n, bus_rdy;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Measured results of one access
    int m_adr, m_ce, m_stb, m_hld, m_pause;
    int m_valid, m_err, m_rdata;
    int bad_side, bad_addr, bad_busy, bad_order;

    always #2 clk = ~clk;

    cs_bus_timer #(.AW(AW), .DW(DW), .CW(CW), .TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mult(cfg_mult),
        .cfg_wait_en(cfg_wait_en), .cfg_adr(cfg_adr), .cfg_ce(cfg_ce),
        .cfg_oe(cfg_oe), .cfg_we(cfg_we), .cfg_rd_hld(cfg_rd_hld),
        .cfg_wr_hld(cfg_wr_hld), .cfg_pause(cfg_pause), .cfg_wait(cfg_wait),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_rdy(bus_rdy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic int mval(input int code);
        case (code)
            0: return 4;
            1: return 1;
            2: return 2;
            default: return 8;
        endcase
    endfunction

    function automatic int plen(input int c, input int code);
        return (c + 1) * mval(code);
    endfunction

    // Runs one access; rdy_at: 0 ready high throughout, -1 never high,
    // n>0 ready raised after the n-th strobe cycle.
    task automatic run_access(input bit wr, input int addr, input int wdata, input int rdy_at);
        bit seen_ce, seen_stb;
        int guard;
        m_adr = 0; m_ce = 0; m_stb = 0; m_hld = 0; m_pause = 0;
        bad_side = 0; bad_addr = 0; bad_busy = 0; bad_order = 0;
        seen_ce = 0; seen_stb = 0; guard = 0;
        @(negedge clk);
        bus_rdy   = (rdy_at == 0);
        bus_rdata = 16'hA500;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_wdata = DW'(wdata);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && guard < 5000) begin
            guard++;
            if (bus_addr != AW'(addr) || bus_wdata_oe != wr || (wr && bus_wdata != DW'(wdata)))
                bad_addr++;
            if (req_ready) bad_busy++;
            if (bus_ce_n) begin
                if (!seen_ce) m_adr++; else m_pause++;
            end else if (!bus_oe_n || !bus_we_n) begin
                if (m_hld > 0) bad_order++;
                if (wr ? (!bus_oe_n) : (!bus_we_n)) bad_side++;
                seen_ce = 1; seen_stb = 1; m_stb++;
                if (rdy_at > 0 && m_stb == rdy_at) bus_rdy = 1'b1;
                bus_rdata = {8'hA5, 8'(m_stb)};
            end else begin
                if (m_pause > 0) bad_order++;
                seen_ce = 1;
                if (!seen_stb) m_ce++; else m_hld++;
            end
            @(negedge clk);
        end
        m_valid = rsp_valid;
        m_err   = rsp_err;
        m_rdata = rsp_rdata;
        bus_rdy = 1'b0;
    endtask

    task automatic set_cfg(input int mult, input int a, input int c, input int oe, input int we,
                           input int rh, input int wh, input int ps);
        cfg_mult = 2'(mult); cfg_adr = CW'(a); cfg_ce = CW'(c); cfg_oe = CW'(oe);
        cfg_we = CW'(we); cfg_rd_hld = CW'(rh); cfg_wr_hld = CW'(wh); cfg_pause = CW'(ps);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ce_n idle", bus_ce_n, 1);
        check("R1 oe_n idle", bus_oe_n, 1);
        check("R1 we_n idle", bus_we_n, 1);
        check("R1 rsp_valid idle", rsp_valid, 0);
        check("R1 req_ready idle", req_ready, 1);
    endtask

    task automatic t_read_basic;
        set_cfg(1, 1, 2, 3, 5, 1, 4, 2);
        cfg_wait_en = 0;
        run_access(0, 16'h1234, 0, 0);
        check("R3 adr phase", m_adr, 2);
        check("R3 ce phase", m_ce, 3);
        check("R4 read strobe width", m_stb, 4);
        check("R4 read hold", m_hld, 2);
        check("R3 pause phase", m_pause, 3);
        check("R6 read data at strobe end", m_rdata, 16'hA504);
        check("R8 rsp_valid at end", m_valid, 1);
        check("R9 no error normal", m_err, 0);
        check("R8 busy ready low", bad_busy, 0);
        check("R3 phase order", bad_order, 0);
        check("R4 read uses oe only", bad_side, 0);
        check("R10 addr stable read", bad_addr, 0);
        @(negedge clk);
        check("R8 rsp pulse one cycle", rsp_valid, 0);
    endtask

    task automatic t_write;
        run_access(1, 16'hBEEF, 16'h5A3C, 0);
        check("R4 write strobe width", m_stb, 6);
        check("R4 write hold", m_hld, 5);
        check("R4 write uses we only", bad_side, 0);
        check("R10 addr/wdata stable write", bad_addr, 0);
        check("R4 write keeps rdata", m_rdata, 16'hA504);
        check("R8 write rsp_valid", m_valid, 1);
    endtask

    task automatic t_mult;
        foreach (mval_codes[i]) begin
            int code;
            int m;
            code = mval_codes[i];
            m = mval(code);
            set_cfg(code, 0, 0, 1, 0, 0, 0, 0);
            run_access(0, 16'h0040 + i, 0, 0);
            check($sformatf("R2 code %0d adr", code), m_adr, plen(0, code));
            check($sformatf("R2 code %0d ce", code), m_ce, plen(0, code));
            check($sformatf("R2 code %0d strobe", code), m_stb, plen(1, code));
            check($sformatf("R2 code %0d hold", code), m_hld, plen(0, code));
            check($sformatf("R2 code %0d pause", code), m_pause, m);
            check($sformatf("R6 code %0d rdata", code), m_rdata, 16'hA500 + 2 * m);
        end
    endtask

    int mval_codes[3] = '{0, 2, 3};

    task automatic t_wait;
        set_cfg(1, 0, 0, 1, 1, 0, 0, 0);
        cfg_wait_en = 1; cfg_wait = CW'(1);
        run_access(0, 16'h0100, 0, 6);
        check("R5 strobe held until ready plus ext", m_stb, 8);
        check("R6 rdata after wait", m_rdata, 16'hA508);
        run_access(0, 16'h0101, 0, 0);
        check("R5 ready already high ext only", m_stb, 4);
        cfg_wait_en = 0;
        run_access(0, 16'h0102, 0, -1);
        check("R5 ready ignored when wait off", m_stb, 2);
        check("R5 no error when wait off", m_err, 0);
    endtask

    task automatic t_timeout;
        set_cfg(1, 0, 0, 1, 1, 0, 0, 0);
        cfg_wait_en = 1;
        run_access(0, 16'h0200, 0, -1);
        check("R9 strobe ends at timeout", m_stb, 2 + TMO);
        check("R9 error flagged", m_err, 1);
        check("R9 valid with error", m_valid, 1);
        check("R9 hold after timeout", m_hld, 1);
        run_access(0, 16'h0201, 0, 0);
        check("R9 error cleared next access", m_err, 0);
        cfg_wait_en = 0;
    endtask

    task automatic t_disabled;
        int bad;
        bad = 0;
        @(negedge clk);
        cfg_en = 0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0300;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (req_ready || !bus_ce_n || !bus_oe_n) bad++;
        end
        req_valid = 1'b0;
        cfg_en = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (!bus_ce_n || rsp_valid) bad++;
        end
        check("R7 disabled requests ignored", bad, 0);
        check("R7 ready back when enabled", req_ready, 1);
    endtask

    initial begin
        rst_n = 0; cfg_en = 1; cfg_wait_en = 0; cfg_wait = '0;
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0);
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        bus_rdata = '0; bus_rdy = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_read_basic();
        t_write();
        t_mult();
        t_wait();
        t_timeout();
        t_disabled();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule